// File: doc/BRIEF.md
# Cache Line Fill Sequencer

This block sits between a CPU read port and external memory, beside a cache whose tag lookup is done elsewhere. Each accepted read carries an address, an access size and a flag saying whether the area is cacheable. The tag lookup result arrives in the same cycle as the request. A cacheable hit is answered from the supplied cached word with no memory traffic. A cacheable miss always fetches the whole 16-byte line as four longword reads, whatever the size or alignment of the original access. A non-cacheable read is passed through once at its own size.

During a fill, each returned longword is written into an internal line buffer and offered to the cache data array through a write strobe. When the last beat lands, the block tells the cache to mark the line valid and returns the requested longword from the filled line. A manual reset (synchronous, active high) that arrives while a fill is running lets the memory read in flight finish, issues no more beats, and tells the cache to invalidate the line. The active-low asynchronous input is the power-on reset, and it clears all state.

Top module: `line_fill_seq`

## Requirements
- R1: After power-on reset, req_ready_o is 1, and mem_valid_o, rsp_valid_o, line_done_o and line_inv_o are 0.
- R2: A cacheable request accepted with hit_i=1 raises rsp_valid_o in the next cycle with rsp_data_o equal to hit_data_i, and no memory read is made.
- R3: A cacheable miss issues exactly four word reads at the line base (address with its low 4 bits cleared) plus 0, 4, 8 and 12, in that order. Each read's data appears on fill_data_o with fill_we_o=1 and fill_addr_o equal to its address.
- R4: A miss on a byte access (size 0) or a halfword access (size 1), including a halfword at address mod 4 = 2, performs the same four-word fill as a word miss, and every fill read has size 2.
- R5: One cycle after the last fill read is accepted, line_done_o and rsp_valid_o are both 1. rsp_data_o is the filled longword selected by address bits [3:2] of the request.
- R6: A non-cacheable request makes one memory read at the request address and size (0 byte, 1 halfword, 2 word) with fill_we_o low, and ignores hit_i. One cycle after that read is accepted, rsp_valid_o is 1 with the read data.
- R7: While mem_valid_o is 1 and mem_ready_i is 0, mem_valid_o, mem_addr_o and mem_size_o stay unchanged.
- R8: If mrst_i is 1 during a fill, the read in flight completes and no further read is issued. One cycle after that read is accepted, line_inv_o pulses, and no response or line_done_o is given.
- R9: If mrst_i is 1 during a non-cacheable read, that read completes and no response is given.
- R10: While mrst_i is 1, req_ready_o is 0, and a request presented then is ignored.
- R11: While a memory read is outstanding, req_ready_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Power-on reset, asynchronous, active low |
| mrst_i | input | 1 | Manual reset, synchronous, active high |
| req_valid_i | input | 1 | CPU read request valid |
| req_ready_o | output | 1 | Request accepted this cycle when valid |
| req_addr_i | input | ADDR_W | Byte address of the read |
| req_size_i | input | 2 | 0 byte, 1 halfword, 2 word |
| req_cacheable_i | input | 1 | Address lies in a cacheable area |
| hit_i | input | 1 | Tag lookup hit, valid with the request |
| hit_data_i | input | DATA_W | Cached longword on a hit |
| rsp_valid_o | output | 1 | Response pulse |
| rsp_data_o | output | DATA_W | Longword containing the requested data |
| mem_valid_o | output | 1 | Memory read request |
| mem_ready_i | input | 1 | Memory accepts the read; data valid this cycle |
| mem_addr_o | output | ADDR_W | Memory read address |
| mem_size_o | output | 2 | Memory read size |
| mem_rdata_i | input | DATA_W | Memory read data |
| fill_we_o | output | 1 | Write strobe to the cache data array |
| fill_addr_o | output | ADDR_W | Longword address being filled |
| fill_data_o | output | DATA_W | Longword being filled |
| line_done_o | output | 1 | Line filled completely; set its valid bit |
| line_inv_o | output | 1 | Fill cut short; clear the line's valid bit |

## Verification
On every cycle, the assertions check four things. The memory request stays stable while the memory stalls. Fill beats advance one longword at a time and are always word-sized. The block refuses requests while a manual reset is high or a read is outstanding. A cut fill stops issuing reads and is never followed by a response. Which longword comes back after a fill, the exact beat at which a manual reset cuts the sequence, and the fact that hits and pass-through reads produce exactly the expected memory traffic can only be shown by the bench. Its memory model checks every read address and every fill write against a queue of expected transfers.

// File: rtl/lfs_pkg.sv
package lfs_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } size_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FILL = 2'd1,
    ST_THRU = 2'd2
  } state_e;
endpackage

// File: rtl/lfs_line_buf.sv
module lfs_line_buf #(
  parameter int DATA_W = 32,
  parameter int BEATS  = 4,
  parameter int IDX_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [DATA_W-1:0] words_q [BEATS];

  for (genvar g = 0; g < BEATS; g++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   words_q[g] <= '0;
      else if (we_i && (wr_idx_i == IDX_W'(g)))      words_q[g] <= wr_data_i;
    end
  end

  // forward the beat being written so the last word is usable in its own cycle
  always_comb begin
    if (we_i && (wr_idx_i == rd_idx_i)) rd_data_o = wr_data_i;
    else                                rd_data_o = words_q[rd_idx_i];
  end
endmodule

// File: rtl/lfs_fsm.sv
module lfs_fsm import lfs_pkg::*; #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int BEATS  = 4,
  localparam int IDX_W = $clog2(BEATS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mrst_i,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [1:0]        req_size_i,
  input  logic              req_cacheable_i,
  input  logic              hit_i,
  input  logic              mem_ready_i,
  output logic              req_ready_o,
  output logic              mem_valid_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [1:0]        mem_size_o,
  output logic [IDX_W-1:0]  word_idx_o,
  output logic [IDX_W-1:0]  beat_idx_o,
  output logic              fill_hs_o,
  output logic              fill_end_o,
  output logic              fill_cut_o,
  output logic              thru_end_o,
  output logic              hit_acc_o
);
  localparam int WB    = $clog2(DATA_W/8);
  localparam int OFF_W = IDX_W + WB;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(BEATS-1);

  state_e            state_q;
  logic [ADDR_W-1:0] addr_q;
  logic [1:0]        size_q;
  logic [IDX_W-1:0]  beat_q;
  logic              abort_q;
  logic              accept, hs, cancel;

  assign accept = req_valid_i && req_ready_o;
  assign hs     = mem_valid_o && mem_ready_i;
  assign cancel = abort_q || mrst_i;

  always_comb begin
    req_ready_o = (state_q == ST_IDLE) && !mrst_i;
    mem_valid_o = (state_q != ST_IDLE);
    if (state_q == ST_FILL) begin
      mem_addr_o = {addr_q[ADDR_W-1:OFF_W], beat_q, {WB{1'b0}}};
      mem_size_o = SZ_WORD;
    end else begin
      mem_addr_o = addr_q;
      mem_size_o = size_q;
    end
  end

  assign word_idx_o = addr_q[OFF_W-1:WB];
  assign beat_idx_o = beat_q;
  assign fill_hs_o  = hs && (state_q == ST_FILL);
  assign fill_end_o = fill_hs_o && (beat_q == LAST) && !cancel;
  assign fill_cut_o = fill_hs_o && cancel;
  assign thru_end_o = hs && (state_q == ST_THRU) && !cancel;
  assign hit_acc_o  = accept && req_cacheable_i && hit_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      size_q  <= SZ_WORD;
      beat_q  <= '0;
      abort_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          abort_q <= 1'b0;
          beat_q  <= '0;
          if (accept) begin
            addr_q <= req_addr_i;
            size_q <= req_size_i;
            if (!req_cacheable_i) state_q <= ST_THRU;
            else if (!hit_i)      state_q <= ST_FILL;
          end
        end
        ST_FILL: begin
          abort_q <= cancel;
          if (hs) begin
            if (cancel || beat_q == LAST) state_q <= ST_IDLE;
            else                          beat_q  <= beat_q + 1'b1;
          end
        end
        ST_THRU: begin
          abort_q <= cancel;
          if (hs) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assert_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_valid_o && !mem_ready_i) |=>
      (mem_valid_o && $stable(mem_addr_o) && $stable(mem_size_o)));

  assert_ascend_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_hs_o && !cancel && beat_q != LAST) |=>
      (mem_valid_o && mem_addr_o == $past(mem_addr_o) + ADDR_W'(DATA_W/8)));

  assert_cut_stop_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_cut_o |=> !mem_valid_o);

  assert_mrst_block_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mrst_i |-> !req_ready_o);

  assert_busy_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o |-> !req_ready_o);
endmodule

// File: rtl/line_fill_seq.sv
module line_fill_seq import lfs_pkg::*; #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int BEATS  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mrst_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [1:0]        req_size_i,
  input  logic              req_cacheable_i,
  input  logic              hit_i,
  input  logic [DATA_W-1:0] hit_data_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_data_o,
  output logic              mem_valid_o,
  input  logic              mem_ready_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [1:0]        mem_size_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              fill_we_o,
  output logic [ADDR_W-1:0] fill_addr_o,
  output logic [DATA_W-1:0] fill_data_o,
  output logic              line_done_o,
  output logic              line_inv_o
);
  localparam int IDX_W = $clog2(BEATS);

  logic [IDX_W-1:0]  word_idx, beat_idx;
  logic              fill_hs, fill_end, fill_cut, thru_end, hit_acc;
  logic [DATA_W-1:0] line_word;
  logic              rsp_valid_q, done_q, inv_q;
  logic [DATA_W-1:0] rsp_data_q;

  lfs_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BEATS(BEATS)) u_fsm (
    .clk_i, .rst_ni, .mrst_i, .req_valid_i, .req_addr_i, .req_size_i,
    .req_cacheable_i, .hit_i, .mem_ready_i, .req_ready_o, .mem_valid_o,
    .mem_addr_o, .mem_size_o,
    .word_idx_o (word_idx),
    .beat_idx_o (beat_idx),
    .fill_hs_o  (fill_hs),
    .fill_end_o (fill_end),
    .fill_cut_o (fill_cut),
    .thru_end_o (thru_end),
    .hit_acc_o  (hit_acc)
  );

  lfs_line_buf #(.DATA_W(DATA_W), .BEATS(BEATS), .IDX_W(IDX_W)) u_buf (
    .clk_i, .rst_ni,
    .we_i      (fill_hs),
    .wr_idx_i  (beat_idx),
    .wr_data_i (mem_rdata_i),
    .rd_idx_i  (word_idx),
    .rd_data_o (line_word)
  );

  assign fill_we_o   = fill_hs;
  assign fill_addr_o = mem_addr_o;
  assign fill_data_o = mem_rdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
      done_q      <= 1'b0;
      inv_q       <= 1'b0;
    end else begin
      rsp_valid_q <= hit_acc || fill_end || thru_end;
      done_q      <= fill_end;
      inv_q       <= fill_cut;
      if (hit_acc)       rsp_data_q <= hit_data_i;
      else if (fill_end) rsp_data_q <= line_word;
      else if (thru_end) rsp_data_q <= mem_rdata_i;
    end
  end

  assign rsp_valid_o = rsp_valid_q;
  assign rsp_data_o  = rsp_data_q;
  assign line_done_o = done_q;
  assign line_inv_o  = inv_q;

  assert_hit_no_bus_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_acc |=> (rsp_valid_o && !mem_valid_o && rsp_data_o == $past(hit_data_i)));

  assert_fill_word_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_we_o |-> (mem_size_o == SZ_WORD));

  assert_done_rsp_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_done_o |-> rsp_valid_o);

  assert_cut_silent_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_inv_o |-> (!rsp_valid_o && !line_done_o));

  assert_thru_nofill_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_valid_o && mem_size_o != SZ_WORD) |-> !fill_we_o);
endmodule

// File: tb/line_fill_seq_bench.sv
module line_fill_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mrst = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic [1:0]  req_size = 2'd2;
  logic        req_cach = 1'b0;
  logic        hit = 1'b0;
  logic [31:0] hit_data = '0;
  logic        rsp_valid;
  logic [31:0] rsp_data;
  logic        mem_valid;
  logic        mem_ready = 1'b0;
  logic [31:0] mem_addr;
  logic [1:0]  mem_size;
  logic [31:0] mem_rdata;
  logic        fill_we;
  logic [31:0] fill_addr, fill_data;
  logic        line_done, line_inv;

  int n_chk = 0, n_fail = 0, stall_n = 0, wait_cnt = 0;

  logic [31:0] exp_rsp_q[$];
  string       exp_rsp_tag_q[$];
  logic [31:0] exp_maddr_q[$];
  logic [1:0]  exp_msize_q[$];
  logic        exp_mfill_q[$];
  logic        exp_evt_q[$];   // 0 line done, 1 line invalidate

  always #2 clk = ~clk;

  function automatic logic [31:0] mdata(logic [31:0] a);
    return a ^ 32'h5A3C_96E1;
  endfunction

  assign mem_rdata = mdata(mem_addr);

  line_fill_seq u_line_fill_seq (
    .clk_i(clk), .rst_ni(rst_n), .mrst_i(mrst), .req_valid_i(req_valid),
    .req_ready_o(req_ready), .req_addr_i(req_addr), .req_size_i(req_size),
    .req_cacheable_i(req_cach), .hit_i(hit), .hit_data_i(hit_data),
    .rsp_valid_o(rsp_valid), .rsp_data_o(rsp_data), .mem_valid_o(mem_valid),
    .mem_ready_i(mem_ready), .mem_addr_o(mem_addr), .mem_size_o(mem_size),
    .mem_rdata_i(mem_rdata), .fill_we_o(fill_we), .fill_addr_o(fill_addr),
    .fill_data_o(fill_data), .line_done_o(line_done), .line_inv_o(line_inv)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  endtask

  // monitor: responses, line events, memory model and fill writes
  always begin
    @(negedge clk);
    if (rst_n) begin
      if (rsp_valid) begin
        if (exp_rsp_q.size() == 0) check(1'b0, "R8/R9 unexpected response", rsp_data, 32'h0);
        else begin
          automatic logic [31:0] e = exp_rsp_q.pop_front();
          automatic string t = exp_rsp_tag_q.pop_front();
          check(rsp_data == e, t, rsp_data, e);
        end
      end
      if (line_done || line_inv) begin
        if (exp_evt_q.size() == 0) check(1'b0, "R5/R8 unexpected line event", {30'd0, line_inv, line_done}, 32'h0);
        else begin
          automatic logic ei = exp_evt_q.pop_front();
          check(line_inv == ei && line_done == !ei, "R5/R8 line event kind",
                {30'd0, line_inv, line_done}, {30'd0, ei, !ei});
        end
      end
      if (mem_valid) begin
        if (wait_cnt < stall_n) begin mem_ready = 1'b0; wait_cnt++; end
        else begin mem_ready = 1'b1; wait_cnt = 0; end
      end else begin
        mem_ready = 1'b0; wait_cnt = 0;
      end
      #1;
      if (mem_valid && mem_ready) begin
        if (exp_maddr_q.size() == 0) check(1'b0, "R2/R8 unexpected memory read", mem_addr, 32'h0);
        else begin
          automatic logic [31:0] ea = exp_maddr_q.pop_front();
          automatic logic [1:0]  es = exp_msize_q.pop_front();
          automatic logic        ef = exp_mfill_q.pop_front();
          check(mem_addr == ea, "R3 memory read address", mem_addr, ea);
          check(mem_size == es, "R4/R6 memory read size", {30'd0, mem_size}, {30'd0, es});
          check(fill_we == ef, "R3/R6 fill strobe", {31'd0, fill_we}, {31'd0, ef});
          if (ef) begin
            check(fill_addr == ea, "R3 fill address", fill_addr, ea);
            check(fill_data == mdata(ea), "R3 fill data", fill_data, mdata(ea));
          end
        end
      end else if (fill_we) check(1'b0, "R3 fill strobe without read", 32'd1, 32'd0);
    end else mem_ready = 1'b0;
  end

  task automatic push_fill(input logic [31:0] a, input string tag);
    for (int i = 0; i < 4; i++) begin
      exp_maddr_q.push_back({a[31:4], 4'h0} + 32'(4 * i));
      exp_msize_q.push_back(2'd2);
      exp_mfill_q.push_back(1'b1);
    end
    exp_evt_q.push_back(1'b0);
    exp_rsp_q.push_back(mdata({a[31:4], a[3:2], 2'b00}));
    exp_rsp_tag_q.push_back(tag);
  endtask

  task automatic send(input logic [31:0] a, input logic [1:0] sz, input logic c,
                      input logic h, input logic [31:0] hd);
    forever begin
      @(negedge clk);
      req_valid = 1'b1; req_addr = a; req_size = sz; req_cach = c; hit = h; hit_data = hd;
      #1;
      if (req_ready) break;
    end
    @(negedge clk);
    req_valid = 1'b0; hit = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (exp_rsp_q.size() == 0 && exp_maddr_q.size() == 0 && exp_evt_q.size() == 0 && !mem_valid) break;
    end
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(req_ready == 1'b1, "R1 req_ready after reset", {31'd0, req_ready}, 32'd1);
    check(mem_valid == 1'b0, "R1 mem_valid after reset", {31'd0, mem_valid}, 32'd0);
    check(rsp_valid == 1'b0 && line_done == 1'b0 && line_inv == 1'b0, "R1 outputs quiet after reset",
          {29'd0, rsp_valid, line_done, line_inv}, 32'd0);

    // R2 hits
    exp_rsp_q.push_back(32'hDEAD_BEEF); exp_rsp_tag_q.push_back("R2 hit data");
    send(32'h0000_0100, 2'd2, 1'b1, 1'b1, 32'hDEAD_BEEF);
    exp_rsp_q.push_back(32'h1234_5678); exp_rsp_tag_q.push_back("R2 hit data byte");
    send(32'h0000_0203, 2'd0, 1'b1, 1'b1, 32'h1234_5678);
    wait_idle();

    // R3/R5 word miss, busy check R11
    push_fill(32'h0000_1008, "R5 word miss response");
    send(32'h0000_1008, 2'd2, 1'b1, 1'b0, 32'h0);
    #1;
    check(req_ready == 1'b0, "R11 busy during fill", {31'd0, req_ready}, 32'd0);
    wait_idle();

    // R4 byte miss and odd halfword miss
    push_fill(32'h0000_2013, "R4 byte miss response");
    send(32'h0000_2013, 2'd0, 1'b1, 1'b0, 32'h0);
    wait_idle();
    push_fill(32'h0000_300E, "R4 halfword mod4=2 miss response");
    send(32'h0000_300E, 2'd1, 1'b1, 1'b0, 32'h0);
    wait_idle();

    // R7 stalled fill, first word of line
    stall_n = 2;
    push_fill(32'h0000_4000, "R7 stalled fill response");
    send(32'h0000_4000, 2'd2, 1'b1, 1'b0, 32'h0);
    wait_idle();

    // R6 pass-through, hit_i ignored
    exp_maddr_q.push_back(32'h0000_5001); exp_msize_q.push_back(2'd0); exp_mfill_q.push_back(1'b0);
    exp_rsp_q.push_back(mdata(32'h0000_5001)); exp_rsp_tag_q.push_back("R6 byte pass-through");
    send(32'h0000_5001, 2'd0, 1'b0, 1'b1, 32'hFFFF_FFFF);
    wait_idle();
    stall_n = 0;
    exp_maddr_q.push_back(32'h0000_5104); exp_msize_q.push_back(2'd2); exp_mfill_q.push_back(1'b0);
    exp_rsp_q.push_back(mdata(32'h0000_5104)); exp_rsp_tag_q.push_back("R6 word pass-through");
    send(32'h0000_5104, 2'd2, 1'b0, 1'b0, 32'h0);
    wait_idle();

    // R8 manual reset mid-fill: beats 0 and 1 only, then invalidate; R10 request ignored
    for (int i = 0; i < 2; i++) begin
      exp_maddr_q.push_back(32'h0000_6000 + 32'(4 * i));
      exp_msize_q.push_back(2'd2);
      exp_mfill_q.push_back(1'b1);
    end
    exp_evt_q.push_back(1'b1);
    send(32'h0000_6008, 2'd2, 1'b1, 1'b0, 32'h0);
    @(negedge clk);
    mrst = 1'b1;
    req_valid = 1'b1; req_addr = 32'h0000_0300; req_size = 2'd2; req_cach = 1'b1; hit = 1'b1; hit_data = 32'hBAD0_BAD0;
    #1;
    check(req_ready == 1'b0, "R10 ready low under manual reset", {31'd0, req_ready}, 32'd0);
    repeat (2) @(negedge clk);
    #1;
    check(req_ready == 1'b0, "R10 ready low while held", {31'd0, req_ready}, 32'd0);
    @(negedge clk);
    mrst = 1'b0; req_valid = 1'b0; hit = 1'b0;
    wait_idle();

    // refill same line normally after the cut
    push_fill(32'h0000_600C, "R5 refill after cut");
    send(32'h0000_600C, 2'd2, 1'b1, 1'b0, 32'h0);
    wait_idle();

    // R9 manual reset during stalled pass-through
    stall_n = 3;
    exp_maddr_q.push_back(32'h0000_7000); exp_msize_q.push_back(2'd2); exp_mfill_q.push_back(1'b0);
    send(32'h0000_7000, 2'd2, 1'b0, 1'b0, 32'h0);
    @(negedge clk);
    mrst = 1'b1;
    repeat (4) @(negedge clk);
    mrst = 1'b0;
    stall_n = 0;
    wait_idle();

    check(exp_maddr_q.size() == 0, "R8/R9 all expected reads seen", 32'(exp_maddr_q.size()), 32'd0);
    check(exp_rsp_q.size() == 0, "R9 all expected responses seen", 32'(exp_rsp_q.size()), 32'd0);
    check(exp_evt_q.size() == 0, "R8 all line events seen", 32'(exp_evt_q.size()), 32'd0);
    finish_run();
  end
endmodule